// File: doc/BRIEF.md
# Dual-Channel Serial Register Bank

This block is the host-facing register unit of a two-channel asynchronous serial controller. The host reaches it over a byte-wide synchronous bus. Each channel has a control port and a data port. Configuration and status registers are reached indirectly. A control write with the pointer at zero loads the pointer. The next control access uses the register that the pointer selects, and the pointer then falls back to zero.

Each channel has a bank of sixteen write registers, exported on a flat bus for the line logic. It also has a read-register space in which only the two status registers carry state. A write to register 9 can carry a command that resets one channel or both. The receive side offers a byte with a valid/ready handshake. The transmit side emits a one-cycle pulse and the byte for every data write that the channel accepts.

Top module: `duo_sio_regbank`

## Requirements
- R1: `bus_addr[1]` picks the port (0 = control, 1 = data). `bus_addr[2]` picks the channel (0 = channel B, index 0; 1 = channel A, index 1).
- R2: A control write with the pointer at 0 loads the pointer from data bits 2:0. It adds 8 only when bits 5:3 equal 3'b001. Other values of bits 5:3 load the low bits alone.
- R3: After a control write with a nonzero pointer, the pointer returns to 0. This does not apply to the reset case of R5. After any control read, the pointer also returns to 0.
- R4: A control write with the pointer at p (p = 1..15) stores the byte into WRp of the addressed channel. For p = 9 the byte is stored only when bits 7:6 are 00. WRp of channel c appears on `wreg_flat[(c*16+p)*8 +: 8]`. The other channel is unchanged. WR0 is never stored and reads 0.
- R5: A write to WR9 with bits 7:6 = 01 resets channel B, 10 resets channel A and 11 resets both. If the writing channel survives the reset, its pointer stays at 9.
- R6: Hardware reset and channel reset give WR4=0x04, WR9=0xC0, WR11=0x08, WR14=0x30, WR15=0xF8, RR0=0x44 and RR1=0x06. Every other register is 0. RR2..RR15 always read 0.
- R7: A data write is accepted only when WR5 bit 3 is set. An accepted write sets RR0 bit 2 and RR1 bit 0, and pulses `tx_fire[c]` with `tx_byte` one cycle after the strobe. A rejected write changes nothing.
- R8: A data read returns the held received byte and clears RR0 bit 0.
- R9: `rx_ready[c]` is high exactly when WR3 bit 0 is set and RR0 bit 0 is clear. A byte offered while it is high is held and sets RR0 bit 0. A byte offered while it is low is dropped.
- R10: `bus_rdata` is registered. It is valid on the cycle after a read strobe and holds otherwise. When both strobes are high, only the write acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Address bits 2:1 (channel, port) |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| rx_valid | input | 2 | Receive byte offered, per channel (0 = B, 1 = A) |
| rx_data_b | input | 8 | Received byte for channel B |
| rx_data_a | input | 8 | Received byte for channel A |
| rx_ready | output | 2 | Receive byte may be loaded, per channel |
| tx_fire | output | 2 | One-cycle pulse per accepted data write |
| tx_byte | output | 8 | Byte of the last accepted data write |
| wreg_flat | output | 256 | All write registers of both channels |

## Verification
The hardest state to reach is a channel that has issued a reset command for the other channel only. That channel still holds pointer 9, and this can be seen only through the next control access on that channel. The stimulus makes channel A reset channel B and then reads channel A's control port. The read must return RR9, which is 0, rather than RR0. A second read confirms that the pointer has returned to 0. The same sequence, mirrored, is run from channel B. The bench also sweeps every write register of both channels through both pointer ranges and checks the whole flat bus against a model after each step.

// File: rtl/duo_sio_pkg.sv
package duo_sio_pkg;
   typedef logic [7:0] byte_t;

   localparam int RR0_RX_AVAIL  = 0;
   localparam int RR0_TX_EMPTY  = 2;
   localparam int RR1_ALL_SENT  = 0;
   localparam int WR3_RX_ENABLE = 0;
   localparam int WR5_TX_ENABLE = 3;
   localparam int REG_CMD_RESET = 9;

   function automatic byte_t wr_init(input int idx);
      case (idx)
         4:       return 8'h04;
         9:       return 8'hC0;
         11:      return 8'h08;
         14:      return 8'h30;
         15:      return 8'hF8;
         default: return 8'h00;
      endcase
   endfunction

   localparam byte_t RR0_INIT = 8'h44;
   localparam byte_t RR1_INIT = 8'h06;
endpackage

// File: rtl/duo_sio_chan.sv
module duo_sio_chan
   import duo_sio_pkg::*;
#(
   parameter int NREG = 16,
   localparam int PW = $clog2(NREG)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              ctl_wr,
   input  logic              ctl_rd,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  byte_t             wdata,
   input  logic              rx_valid,
   input  byte_t             rx_data,
   output logic              rx_ready,
   output logic [1:0]        rst_cmd,
   output logic              tx_fire,
   output byte_t             ctl_rdata,
   output byte_t             dat_rdata,
   output logic [NREG*8-1:0] wregs
);
   if (NREG != 16) begin : g_bad_nreg
      $error("duo_sio_chan: NREG must be 16");
   end

   logic [PW-1:0] ptr;
   byte_t         wr_q [NREG];
   byte_t         rr0, rr1, rx_hold;
   logic          ptr_is_cmd;
   logic          rx_take;

   assign ptr_is_cmd = (ptr == PW'(REG_CMD_RESET));
   assign rst_cmd    = (ctl_wr && ptr_is_cmd) ? wdata[7:6] : 2'b00;
   assign rx_ready   = wr_q[3][WR3_RX_ENABLE] & ~rr0[RR0_RX_AVAIL];
   assign rx_take    = rx_valid & rx_ready;
   assign tx_fire    = dat_wr & wr_q[5][WR5_TX_ENABLE];
   assign dat_rdata  = rx_hold;

   always_comb begin
      case (ptr)
         PW'(0):  ctl_rdata = rr0;
         PW'(1):  ctl_rdata = rr1;
         default: ctl_rdata = 8'h00;
      endcase
   end

   for (genvar r = 0; r < NREG; r++) begin : g_flat
      assign wregs[r*8 +: 8] = wr_q[r];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         rr0     <= RR0_INIT;
         rr1     <= RR1_INIT;
         rx_hold <= 8'h00;
         for (int i = 0; i < NREG; i++) wr_q[i] <= wr_init(i);
      end else if (soft_rst) begin
         ptr     <= '0;
         rr0     <= RR0_INIT;
         rr1     <= RR1_INIT;
         rx_hold <= 8'h00;
         for (int i = 0; i < NREG; i++) wr_q[i] <= wr_init(i);
      end else begin
         if (ctl_wr) begin
            if (ptr == '0) begin
               ptr <= {(wdata[5:3] == 3'b001), wdata[2:0]};
            end else if (ptr_is_cmd) begin
               if (wdata[7:6] == 2'b00) begin
                  wr_q[ptr] <= wdata;
                  ptr       <= '0;
               end
            end else begin
               wr_q[ptr] <= wdata;
               ptr       <= '0;
            end
         end
         if (ctl_rd) ptr <= '0;
         if (tx_fire) begin
            rr0[RR0_TX_EMPTY] <= 1'b1;
            rr1[RR1_ALL_SENT] <= 1'b1;
         end
         if (dat_rd) rr0[RR0_RX_AVAIL] <= 1'b0;
         if (rx_take) begin
            rx_hold           <= rx_data;
            rr0[RR0_RX_AVAIL] <= 1'b1;
         end
      end
   end

   a_r3_rd_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |=> ptr == '0);
   a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !soft_rst) |=> $stable(rx_hold));
   a_r7_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !wr_q[5][WR5_TX_ENABLE] && !soft_rst) |=> $stable(rr1));
   a_r6_soft_values: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (rr0 == RR0_INIT) && (rr1 == RR1_INIT));
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !rx_take && !soft_rst) |=> !rr0[RR0_RX_AVAIL]);
endmodule

// File: rtl/duo_sio_regbank.sv
module duo_sio_regbank
   import duo_sio_pkg::*;
#(
   parameter int NREG = 16,
   parameter int NCH  = 2,
   localparam int FLATW = NCH*NREG*8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:1]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [1:0]       rx_valid,
   input  logic [7:0]       rx_data_b,
   input  logic [7:0]       rx_data_a,
   output logic [1:0]       rx_ready,
   output logic [1:0]       tx_fire,
   output logic [7:0]       tx_byte,
   output logic [FLATW-1:0] wreg_flat
);
   if (NCH != 2) begin : g_bad_nch
      $error("duo_sio_regbank: NCH must be 2");
   end

   logic        rd_ok;
   logic [1:0]  cmd_of [NCH];
   logic [NCH-1:0] soft_rst, fire_c;
   byte_t       ctl_rd_v [NCH];
   byte_t       dat_rd_v [NCH];
   byte_t       rx_in    [NCH];

   assign rd_ok    = bus_rd & ~bus_wr;
   assign rx_in[0] = rx_data_b;
   assign rx_in[1] = rx_data_a;

   always_comb begin
      soft_rst = '0;
      for (int c = 0; c < NCH; c++) soft_rst |= cmd_of[c];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = (bus_addr[2] == 1'(c));
      duo_sio_chan #(.NREG(NREG)) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_rst  (soft_rst[c]),
         .ctl_wr    (bus_wr & hit & ~bus_addr[1]),
         .ctl_rd    (rd_ok  & hit & ~bus_addr[1]),
         .dat_wr    (bus_wr & hit &  bus_addr[1]),
         .dat_rd    (rd_ok  & hit &  bus_addr[1]),
         .wdata     (bus_wdata),
         .rx_valid  (rx_valid[c]),
         .rx_data   (rx_in[c]),
         .rx_ready  (rx_ready[c]),
         .rst_cmd   (cmd_of[c]),
         .tx_fire   (fire_c[c]),
         .ctl_rdata (ctl_rd_v[c]),
         .dat_rdata (dat_rd_v[c]),
         .wregs     (wreg_flat[c*NREG*8 +: NREG*8])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= 8'h00;
         tx_fire   <= 2'b00;
         tx_byte   <= 8'h00;
      end else begin
         if (rd_ok)
            bus_rdata <= bus_addr[1] ? dat_rd_v[bus_addr[2]] : ctl_rd_v[bus_addr[2]];
         tx_fire <= fire_c;
         if (|fire_c) tx_byte <= bus_wdata;
      end
   end

   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ok |=> $stable(bus_rdata));
   a_r1_one_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_fire));
   a_r5_cmd_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |-> soft_rst == '0);
endmodule

// File: tb/duo_sio_regbank_tb.sv
module duo_sio_regbank_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:1]   bus_addr = '0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]   bus_wdata = '0;
   logic [7:0]   bus_rdata;
   logic [1:0]   rx_valid = '0;
   logic [7:0]   rx_data_b = '0, rx_data_a = '0;
   logic [1:0]   rx_ready, tx_fire;
   logic [7:0]   tx_byte;
   logic [255:0] wreg_flat;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [7:0] mdl [2][16];

   always #2 clk = ~clk;

   duo_sio_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
      .rx_data_b(rx_data_b), .rx_data_a(rx_data_a), .rx_ready(rx_ready),
      .tx_fire(tx_fire), .tx_byte(tx_byte), .wreg_flat(wreg_flat));

   function automatic logic [7:0] init_val(int r);
      if (r == 4) return 8'h04;
      if (r == 9) return 8'hC0;
      if (r == 11) return 8'h08;
      if (r == 14) return 8'h30;
      if (r == 15) return 8'hF8;
      return 8'h00;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic mdl_reset(int c);
      for (int r = 0; r < 16; r++) mdl[c][r] = init_val(r);
   endtask

   task automatic chk_flat(string req);
      for (int c = 0; c < 2; c++)
         for (int r = 0; r < 16; r++)
            chk(req, wreg_flat[(c*16+r)*8 +: 8], mdl[c][r]);
   endtask

   // address: ch 0 = B, 1 = A; port 0 = control, 1 = data
   task automatic wr(int ch, int port, logic [7:0] d);
      @(negedge clk);
      bus_addr = {ch[0], port[0]}; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int ch, int port, output logic [7:0] d);
      @(negedge clk);
      bus_addr = {ch[0], port[0]}; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic sel(int ch, int r);
      wr(ch, 0, (r < 8) ? 8'(r) : (8'h08 | 8'(r - 8)));
   endtask

   task automatic rx_offer(int ch, logic [7:0] d);
      @(negedge clk);
      rx_valid[ch] = 1'b1;
      if (ch == 0) rx_data_b = d; else rx_data_a = d;
      @(negedge clk);
      rx_valid = '0;
   endtask

   initial begin
      #400000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      mdl_reset(0); mdl_reset(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_flat("R6 reset write regs");
      for (int c = 0; c < 2; c++) begin
         rd(c, 0, v); chk("R6 RR0 reset", v, 8'h44);
         sel(c, 1); rd(c, 0, v); chk("R6 RR1 reset", v, 8'h06);
         rd(c, 0, v); chk("R3 ptr back to 0 after read", v, 8'h44);
      end
      for (int r = 2; r < 16; r++) begin
         sel(1, r); rd(1, 0, v); chk("R6 RR2..15 zero", v, 8'h00);
      end
      chk("R9 ready low after reset", {6'b0, rx_ready}, 8'h00);

      // R4 sweep of every register, both channels, both pointer ranges
      for (int c = 0; c < 2; c++)
         for (int r = 1; r < 16; r++) begin
            logic [7:0] d;
            d = 8'(r * 13 + c * 90) & ((r == 9) ? 8'h3F : 8'hFF);
            if (r == 3 || r == 5) d = d & 8'hF6;
            sel(c, r); wr(c, 0, d);
            mdl[c][r] = d;
            @(negedge clk);
            chk_flat("R4 register sweep");
            rd(c, 0, v); chk("R3 ptr zero after reg write", v, 8'h44);
         end

      // R2: bits 5:3 other than 001 do not add 8
      wr(0, 0, 8'h13); wr(0, 0, 8'h5C);
      mdl[0][3] = 8'h5C; @(negedge clk);
      chk("R2 code 010 loads low bits", wreg_flat[3*8 +: 8], 8'h5C);
      chk("R2 WR11 untouched", wreg_flat[11*8 +: 8], mdl[0][11]);
      wr(0, 0, 8'h0B); wr(0, 0, 8'h66); mdl[0][11] = 8'h66; @(negedge clk);
      chk("R2 code 001 adds 8", wreg_flat[11*8 +: 8], 8'h66);
      wr(0, 0, 8'h03); wr(0, 0, 8'h00); mdl[0][3] = 8'h00;

      // R5: A resets B, A keeps pointer 9
      sel(1, 9); wr(1, 0, 8'h40); mdl_reset(0); @(negedge clk);
      chk_flat("R5 A resets B");
      rd(1, 0, v); chk("R5 surviving ptr stays 9", v, 8'h00);
      rd(1, 0, v); chk("R3 ptr zero after read", v, 8'h44);
      sel(0, 9); wr(0, 0, 8'h80); mdl_reset(1); @(negedge clk);
      chk_flat("R5 B resets A");
      rd(0, 0, v); chk("R5 surviving ptr stays 9 on B", v, 8'h00);
      sel(0, 4); wr(0, 0, 8'hAA); mdl[0][4] = 8'hAA;
      sel(1, 7); wr(1, 0, 8'hBB); mdl[1][7] = 8'hBB;
      sel(1, 9); wr(1, 0, 8'hC0); mdl_reset(0); mdl_reset(1); @(negedge clk);
      chk_flat("R5 full reset");
      rd(1, 0, v); chk("R5 reset channel ptr zero", v, 8'h44);

      // R7 transmit gate on channel B
      wr(0, 1, 8'h3C);
      chk("R7 rejected write no fire", {6'b0, tx_fire}, 8'h00);
      sel(0, 1); rd(0, 0, v); chk("R7 rejected RR1 unchanged", v, 8'h06);
      sel(0, 5); wr(0, 0, 8'h08);
      @(negedge clk);
      bus_addr = 2'b01; bus_wdata = 8'hE7; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R7 fire pulse B", {6'b0, tx_fire}, 8'h01);
      chk("R7 tx byte", tx_byte, 8'hE7);
      @(negedge clk);
      chk("R7 pulse one cycle", {6'b0, tx_fire}, 8'h00);
      sel(0, 1); rd(0, 0, v); chk("R7 all sent set", v, 8'h07);
      // R1: channel A data write gated by A's own WR5 (still 0)
      wr(1, 1, 8'h11);
      chk("R1 A not enabled", {6'b0, tx_fire}, 8'h00);

      // R9 / R8 receive on channel A
      sel(1, 3); wr(1, 0, 8'h01); @(negedge clk);
      chk("R9 ready after enable", {6'b0, rx_ready}, 8'h02);
      rx_offer(1, 8'h9D);
      chk("R9 ready drops when held", {6'b0, rx_ready}, 8'h00);
      rd(1, 0, v); chk("R9 RR0 rx avail", v, 8'h45);
      rx_offer(1, 8'h12);
      rd(1, 1, v); chk("R8 data read keeps first byte", v, 8'h9D);
      rd(1, 0, v); chk("R8 avail cleared", v, 8'h44);
      chk("R9 ready again", {6'b0, rx_ready}, 8'h02);
      rx_offer(0, 8'h55);
      rd(0, 0, v); chk("R9 B not enabled ignores byte", v, 8'h44);

      // R10: hold and write precedence
      @(negedge clk); @(negedge clk);
      chk("R10 rdata holds", bus_rdata, 8'h44);
      @(negedge clk);
      bus_addr = 2'b10; bus_wdata = 8'h01; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R10 read ignored with write", bus_rdata, 8'h44);
      rd(1, 0, v); chk("R10 write acted (ptr 1)", v, 8'h06);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule